// File: doc/BRIEF.md
# Planar Video Memory Write Data Path

This block sits between a processor write port and a video memory that is split into four bit planes, each one byte wide at a given address. For every processor write it forms the byte to store in each plane and the write enable of each plane. Its inputs are the processor byte, the four bytes that were latched by an earlier memory read, and a set of control fields. The control fields are a write mode, a rotate count, a logic function, a per-plane constant colour, a per-plane enable for that constant, and a bit mask. A separate 4-bit plane-enable mask comes from outside and sets which planes are written.

The four write modes support different drawing operations. Mode 0 rotates the byte, can replace it with a constant in some planes, and then merges it with the latches. Mode 1 writes the latches back unchanged, which copies memory to memory. Mode 2 writes one colour to each pixel. Mode 3 fills a pattern in the constant colour. The result can leave the block through a register or go straight out, as set by a parameter. The default is registered, with one cycle of latency and a synchronous active-high reset.

Top module: `planar_wdata`

## Requirements
- R1: In mode 0 (`wr_mode`=0), with `const_en`=0, `logic_fn`=0 and `pix_mask`=0xFF, every plane receives `cpu_byte` rotated right by `rot_cnt` positions (result bit b = input bit (b+`rot_cnt`) mod 8).
- R2: In mode 0, every plane p whose `const_en[p]` is 1 uses 0xFF (when `const_col[p]`=1) or 0x00 (when `const_col[p]`=0) in place of the rotated byte. Planes whose `const_en` bit is 0 keep the rotated byte.
- R3: In modes 0 and 2, the per-plane value is merged with that plane's latch according to `logic_fn`: 0 passes it through, 1 is AND, 2 is OR, 3 is XOR.
- R4: In modes 0 and 2, each bit position where `pix_mask` is 1 takes the merged value. Each position where it is 0 takes the plane's latch bit.
- R5: In mode 1, every plane receives its latch byte, whatever the values of `cpu_byte`, `pix_mask`, `logic_fn` and the constant fields.
- R6: In mode 2, bit p of `cpu_byte` (p = 0..3) is copied to all 8 bits of plane p before the merge and the masking. `rot_cnt` and `const_en` have no effect.
- R7: In mode 3, the select byte is the rotated `cpu_byte` ANDed with `pix_mask`. Selected bits of plane p take `const_col[p]`, and unselected bits take the latch bit. `logic_fn` and `const_en` have no effect.
- R8: `plane_we` equals `plane_en` in every write mode.
- R9: A `rot_cnt` of 0 leaves the byte unchanged. A `rot_cnt` of 7 gives the same result as rotating left by one.
- R10: With `OUT_REG`=1 (the default), the outputs show the result for the inputs present at the previous rising clock edge. A cycle with `rst` high sets `plane_data` and `plane_we` to zero.

Plane p occupies bits [8p+7:8p] of `latch_in` and of `plane_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cpu_byte | input | 8 | Byte written by the processor |
| latch_in | input | 32 | Latched plane bytes; plane p at [8p+7:8p] |
| wr_mode | input | 2 | Write mode 0..3 |
| rot_cnt | input | 3 | Rotate-right count |
| logic_fn | input | 2 | Latch merge function: 0 pass, 1 AND, 2 OR, 3 XOR |
| const_col | input | 4 | Per-plane constant colour bit |
| const_en | input | 4 | Per-plane enable for the constant in mode 0 |
| pix_mask | input | 8 | Per-pixel write mask |
| plane_en | input | 4 | External plane-enable mask |
| plane_data | output | 32 | Bytes to write; plane p at [8p+7:8p] |
| plane_we | output | 4 | Per-plane write enables |

## Verification
On every cycle the assertions check the properties that hold for any operands. Mode 1 must return the latches. Masked-off bits in modes 0 and 2 must equal the latch. Unselected bits in mode 3 must equal the latch. The register must hold the previous cycle's result, and the write enables must follow the plane-enable mask. The exact values show only in the bench's scenarios, which compare the outputs with an independent bit-level model. These values are the rotation amounts including the wrap cases, the constant substitution per plane, each of the four merge functions, the colour copying of mode 2, and the pattern fill of mode 3.

// File: rtl/planar_wr_pkg.sv
package planar_wr_pkg;

    typedef enum logic [1:0] {
        WM_MERGE = 2'd0,
        WM_COPY  = 2'd1,
        WM_COLOR = 2'd2,
        WM_FILL  = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XOR  = 2'd3
    } lfunc_e;

    typedef struct packed {
        wmode_e mode;
        lfunc_e fn;
    } wctl_t;

    function automatic logic [7:0] apply_fn(lfunc_e f, logic [7:0] v, logic [7:0] l);
        case (f)
            FN_AND:  return v & l;
            FN_OR:   return v | l;
            FN_XOR:  return v ^ l;
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/pw_rotator.sv
module pw_rotator #(
    parameter int W     = 8,
    localparam int CW   = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] dbl;

    always_comb begin
        dbl  = {din, din} >> cnt;
        dout = dbl[W-1:0];
    end
endmodule

// File: rtl/pw_plane_unit.sv
module pw_plane_unit
    import planar_wr_pkg::*;
(
    input  wctl_t       ctl,
    input  logic [7:0]  rot_byte,
    input  logic        cpu_bit,
    input  logic        col,
    input  logic        col_en,
    input  logic [7:0]  latch,
    input  logic [7:0]  mask,
    output logic [7:0]  res
);
    logic [7:0] src;
    logic [7:0] merged;
    logic [7:0] sel;

    always_comb begin
        src    = (ctl.mode == WM_COLOR) ? {8{cpu_bit}}
               : (col_en ? {8{col}} : rot_byte);
        merged = apply_fn(ctl.fn, src, latch);
        sel    = rot_byte & mask;
        case (ctl.mode)
            WM_COPY: res = latch;
            WM_FILL: res = (sel & {8{col}}) | (latch & ~sel);
            default: res = (merged & mask) | (latch & ~mask);
        endcase
    end
endmodule

// File: rtl/pw_out_stage.sv
module pw_out_stage #(
    parameter int DW      = 32,
    parameter int NP      = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d_in,
    input  logic [NP-1:0] we_in,
    output logic [DW-1:0] d_out,
    output logic [NP-1:0] we_out
);
    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_out  <= '0;
                    we_out <= '0;
                end else begin
                    d_out  <= d_in;
                    we_out <= we_in;
                end
            end
        end else begin : g_pass
            assign d_out  = d_in;
            assign we_out = we_in;
        end
    endgenerate
endmodule

// File: rtl/planar_wdata.sv
module planar_wdata
    import planar_wr_pkg::*;
#(
    parameter int  N_PLANES = 4,
    parameter int  PIX_W    = 8,
    parameter bit  OUT_REG  = 1'b1,
    localparam int CNT_W    = $clog2(PIX_W),
    localparam int DATA_W   = N_PLANES * PIX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PIX_W-1:0]    cpu_byte,
    input  logic [DATA_W-1:0]   latch_in,
    input  logic [1:0]          wr_mode,
    input  logic [CNT_W-1:0]    rot_cnt,
    input  logic [1:0]          logic_fn,
    input  logic [N_PLANES-1:0] const_col,
    input  logic [N_PLANES-1:0] const_en,
    input  logic [PIX_W-1:0]    pix_mask,
    input  logic [N_PLANES-1:0] plane_en,
    output logic [DATA_W-1:0]   plane_data,
    output logic [N_PLANES-1:0] plane_we
);
    wctl_t             ctl;
    logic [PIX_W-1:0]  rot_byte;
    logic [DATA_W-1:0] nxt_data;

    assign ctl.mode = wmode_e'(wr_mode);
    assign ctl.fn   = lfunc_e'(logic_fn);

    pw_rotator #(.W(PIX_W)) u_rot (
        .din  (cpu_byte),
        .cnt  (rot_cnt),
        .dout (rot_byte)
    );

    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        pw_plane_unit u_pu (
            .ctl      (ctl),
            .rot_byte (rot_byte),
            .cpu_bit  (cpu_byte[p]),
            .col      (const_col[p]),
            .col_en   (const_en[p]),
            .latch    (latch_in[p*PIX_W +: PIX_W]),
            .mask     (pix_mask),
            .res      (nxt_data[p*PIX_W +: PIX_W])
        );
    end

    pw_out_stage #(.DW(DATA_W), .NP(N_PLANES), .OUT_REG(OUT_REG)) u_out (
        .clk    (clk),
        .rst    (rst),
        .d_in   (nxt_data),
        .we_in  (plane_en),
        .d_out  (plane_data),
        .we_out (plane_we)
    );

    // R5
    copy_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_mode == 2'd1) |-> (nxt_data == latch_in));

    // R4
    mask_keeps_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_mode[0] == 1'b0) |-> (((nxt_data ^ latch_in) & ~{N_PLANES{pix_mask}}) == '0));

    // R7
    fill_unselected_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_mode == 2'd3) |-> (((nxt_data ^ latch_in) & ~{N_PLANES{rot_byte & pix_mask}}) == '0));

    generate
        if (OUT_REG) begin : g_reg_chk
            logic q_live;
            always_ff @(posedge clk) begin
                if (rst) q_live <= 1'b0;
                else     q_live <= 1'b1;
            end

            // R8
            we_follow_chk: assert property (@(posedge clk) disable iff (rst)
                q_live |-> (plane_we == $past(plane_en)));

            // R10
            reg_latency_chk: assert property (@(posedge clk) disable iff (rst)
                q_live |-> (plane_data == $past(nxt_data)));
        end
    endgenerate
endmodule

// File: tb/planar_wdata_tb.sv
module planar_wdata_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cpu_byte = '0;
    logic [31:0] latch_in = '0;
    logic [1:0]  wr_mode  = '0;
    logic [2:0]  rot_cnt  = '0;
    logic [1:0]  logic_fn = '0;
    logic [3:0]  const_col = '0;
    logic [3:0]  const_en  = '0;
    logic [7:0]  pix_mask  = '0;
    logic [3:0]  plane_en  = '0;
    logic [31:0] plane_data;
    logic [3:0]  plane_we;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [31:0] d;
        logic [3:0]  we;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    planar_wdata u_dut (
        .clk(clk), .rst(rst), .cpu_byte(cpu_byte), .latch_in(latch_in),
        .wr_mode(wr_mode), .rot_cnt(rot_cnt), .logic_fn(logic_fn),
        .const_col(const_col), .const_en(const_en), .pix_mask(pix_mask),
        .plane_en(plane_en), .plane_data(plane_data), .plane_we(plane_we)
    );

    function automatic logic [31:0] model(logic [1:0] m, logic [2:0] r, logic [1:0] f,
                                          logic [3:0] sr, logic [3:0] esr, logic [7:0] cpu,
                                          logic [7:0] msk, logic [31:0] lat);
        logic [31:0] o;
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 8; b++) begin
                logic rb, v, l;
                rb = cpu[(b + r) % 8];
                l  = lat[p*8 + b];
                case (m)
                    2'd1: o[p*8+b] = l;
                    2'd3: o[p*8+b] = (rb && msk[b]) ? sr[p] : l;
                    default: begin
                        if (m == 2'd2)   v = cpu[p];
                        else if (esr[p]) v = sr[p];
                        else             v = rb;
                        if (f == 2'd1)      v = v & l;
                        else if (f == 2'd2) v = v | l;
                        else if (f == 2'd3) v = v ^ l;
                        o[p*8+b] = msk[b] ? v : l;
                    end
                endcase
            end
        end
        return o;
    endfunction

    task automatic drive(input logic [1:0] m, input logic [2:0] r, input logic [1:0] f,
                         input logic [3:0] sr, input logic [3:0] esr, input logic [7:0] cpu,
                         input logic [7:0] msk, input logic [31:0] lat, input logic [3:0] pe,
                         input string tag);
        exp_t e;
        @(negedge clk);
        wr_mode = m; rot_cnt = r; logic_fn = f; const_col = sr; const_en = esr;
        cpu_byte = cpu; pix_mask = msk; latch_in = lat; plane_en = pe;
        e.d = model(m, r, f, sr, esr, cpu, msk, lat);
        e.we = pe;
        e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (plane_data !== e.d || plane_we !== e.we) begin
                n_fails++;
                $display("FAIL %s: data=%h we=%h expected data=%h we=%h",
                         e.tag, plane_data, plane_we, e.d, e.we);
            end
        end
    end

    task automatic check_zero(input string tag);
        n_checks++;
        if (plane_data !== '0 || plane_we !== '0) begin
            n_fails++;
            $display("FAIL %s: data=%h we=%h expected data=0 we=0", tag, plane_data, plane_we);
        end
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        cpu_byte = 8'hA5; latch_in = 32'h1234_5678; plane_en = 4'hF; pix_mask = 8'hFF;
        repeat (3) @(posedge clk);
        #2;
        check_zero("R10 reset");
        @(negedge clk) rst = 1'b0;

        // R1: plain rotation
        drive(2'd0, 3'd3, 2'd0, 4'h0, 4'h0, 8'b1000_0110, 8'hFF, 32'h0, 4'hF, "R1 rot3");
        drive(2'd0, 3'd1, 2'd0, 4'h0, 4'h0, 8'h01, 8'hFF, 32'hFFFF_FFFF, 4'hF, "R1 rot1 wrap");
        // R9: boundary counts
        drive(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'h6C, 8'hFF, 32'h0, 4'hF, "R9 rot0");
        drive(2'd0, 3'd7, 2'd0, 4'h0, 4'h0, 8'h81, 8'hFF, 32'h0, 4'hF, "R9 rot7");
        // R2: constant substitution, mixed planes
        drive(2'd0, 3'd2, 2'd0, 4'b0101, 4'b0011, 8'h3C, 8'hFF, 32'h0, 4'hF, "R2 const");
        // R3: each function code
        drive(2'd0, 3'd0, 2'd1, 4'h0, 4'h0, 8'hF0, 8'hFF, 32'hCCAA_5533, 4'hF, "R3 and");
        drive(2'd0, 3'd0, 2'd2, 4'h0, 4'h0, 8'hF0, 8'hFF, 32'hCCAA_5533, 4'hF, "R3 or");
        drive(2'd0, 3'd0, 2'd3, 4'h0, 4'h0, 8'hF0, 8'hFF, 32'hCCAA_5533, 4'hF, "R3 xor");
        drive(2'd2, 3'd0, 2'd3, 4'h0, 4'h0, 8'h05, 8'hFF, 32'hCCAA_5533, 4'hF, "R3 xor mode2");
        // R4: bit mask
        drive(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'h00, 8'h0F, 32'hFFFF_FFFF, 4'hF, "R4 mask");
        drive(2'd2, 3'd0, 2'd0, 4'h0, 4'h0, 8'h0A, 8'h3C, 32'h1122_3344, 4'hF, "R4 mask mode2");
        // R5: copy ignores everything but the latches
        drive(2'd1, 3'd5, 2'd3, 4'hF, 4'hF, 8'hFF, 8'h00, 32'hDEAD_BEEF, 4'hF, "R5 copy");
        // R6: colour expand, rotate and const enable have no effect
        drive(2'd2, 3'd4, 2'd0, 4'hF, 4'hF, 8'hF9, 8'hFF, 32'h0, 4'hF, "R6 color");
        // R7: pattern fill
        drive(2'd3, 3'd1, 2'd2, 4'b1010, 4'h0, 8'hB4, 8'hF0, 32'h0F0F_3355, 4'hF, "R7 fill");
        drive(2'd3, 3'd0, 2'd0, 4'b0110, 4'hF, 8'hFF, 8'hFF, 32'h8888_8888, 4'hF, "R7 fill full");
        // R8: plane enables in each mode
        drive(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'h11, 8'hFF, 32'h0, 4'b0001, "R8 mode0");
        drive(2'd1, 3'd0, 2'd0, 4'h0, 4'h0, 8'h22, 8'hFF, 32'h1, 4'b0110, "R8 mode1");
        drive(2'd2, 3'd0, 2'd0, 4'h0, 4'h0, 8'h33, 8'hFF, 32'h2, 4'b1000, "R8 mode2");
        drive(2'd3, 3'd0, 2'd0, 4'h0, 4'h0, 8'h44, 8'hFF, 32'h3, 4'b0000, "R8 mode3");
        // R10: back-to-back latency
        drive(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'h5A, 8'hFF, 32'h0, 4'hF, "R10 seq a");
        drive(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hA5, 8'hFF, 32'h0, 4'hF, "R10 seq b");
        repeat (3) @(posedge clk);

        // R10: reset during operation clears the outputs
        @(negedge clk);
        rst = 1'b1;
        wr_mode = 2'd1; latch_in = 32'hFFFF_FFFF; plane_en = 4'hF;
        @(posedge clk);
        #2;
        check_zero("R10 reset mid-run");
        @(negedge clk) rst = 1'b0;
        repeat (2) @(posedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule